// File: doc/BRIEF.md
# Ping-Pong Endpoint DMA Request Pacer

This block sits between an external DMA controller and one endpoint that owns two packet buffers, called ping and pong. It paces the transfer with a level request (`dreq`) and an acknowledge (`dack`) from the controller. One byte moves on each clock in which the request, the acknowledge and the byte strobe are all high. In IN mode (`dir_out` = 0) the controller writes bytes into a free buffer, and the block hands a finished buffer to the USB side. In OUT mode (`dir_out` = 1) the USB side deposits packets, and the controller reads them back out.

The transfer starts when the enable rises. It then proceeds in bursts of a programmable length. After each burst the request drops, and it is raised again only once the controller has let go of the acknowledge. The DMA side and the USB side each walk the two buffers alternately, ping first. The DMA side fills or drains the buffer that the USB side is not using. The transfer ends in one of three ways: the programmed byte total is reached, the enable is cleared, or the controller strobes end-of-transfer. A single-cycle `done` pulse marks the end.

Configuration inputs (`dir_out`, `cfg_size`, `cfg_burst`, `cfg_total`) are held stable while `busy` is high.

Top module: `dma_pingpong_ctl`

## Requirements
- R1: In IN mode `dreq` is high only while a transfer runs and the buffer selected by `dma_sel` is free (its `buf_rdy` bit is 0).
- R2: In OUT mode `dreq` is high only while a transfer runs and the buffer selected by `dma_sel` holds a packet (its `buf_rdy` bit is 1).
- R3: A byte moves only on a clock where `dreq`, `dack` and `dstb` are all high. A burst carries at most `cfg_burst` bytes, and a value of 0 means 2^BW bytes. Strobes outside such clocks change nothing.
- R4: After `dreq` falls, it rises again only after a clock on which `dack` was low. It rises on the clock after that one if the run continues and the R1/R2 condition holds.
- R5: In IN mode, the byte that brings the active buffer to `cfg_size` drops `dreq`. It also sets that buffer's `buf_rdy` bit, records its length as `cfg_size`, and toggles `dma_sel`.
- R6: In OUT mode, reading the last byte of the active buffer's packet drops `dreq`, clears that buffer's `buf_rdy` bit and toggles `dma_sel`.
- R7: A run ends on the byte that reaches `cfg_total` bytes, where 0 means 2^TW bytes. It also ends when `en` is low or `eot` is high. Ending drops `dreq` and `busy`, and `done` is high on the following cycle.
- R8: In IN mode, a run that ends with a partly filled active buffer sets that buffer's `buf_rdy` bit, records the bytes written as its length, and toggles `dma_sel`. A run that ends with zero bytes in the active buffer leaves the buffers unchanged.
- R9: The USB side uses ping and pong alternately, starting with ping. In IN mode `usb_pop` frees its buffer if that buffer is ready. In OUT mode `usb_push` loads its buffer with length `usb_len` if that buffer is empty. A pop of a non-ready buffer has no effect, and neither does a push of length 0.
- R10: `done` lasts exactly one cycle. No new run starts until `en` has been seen low and then high again.
- R11: After reset, `dreq`, `done` and `busy` are low, both `buf_rdy` bits are 0, both lengths are 0 and `dma_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | DMA enable; a rise starts a run, a clear ends it |
| dir_out | input | 1 | 0 = IN (controller writes), 1 = OUT (controller reads) |
| cfg_size | input | LENW | Buffer capacity in bytes for IN mode (nonzero) |
| cfg_burst | input | BW | Bytes per burst, 0 = 2^BW |
| cfg_total | input | TW | Bytes per run, 0 = 2^TW |
| dreq | output | 1 | Burst request to the DMA controller |
| dack | input | 1 | Acknowledge from the DMA controller |
| dstb | input | 1 | Byte strobe from the DMA controller |
| eot | input | 1 | End-of-transfer strobe from the DMA controller |
| usb_pop | input | 1 | USB side has sent its current buffer (IN mode) |
| usb_push | input | 1 | USB side deposits a packet (OUT mode) |
| usb_len | input | LENW | Length of the deposited packet |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| dma_sel | output | 1 | Buffer used by the DMA side (0 = ping, 1 = pong) |
| buf_rdy | output | 2 | Per buffer: ready for host (IN) or holds packet (OUT) |
| len0 | output | LENW | Byte length recorded for ping |
| len1 | output | LENW | Byte length recorded for pong |

## Verification
The bench counts every burst and compares its length with the smallest of three values: the burst limit, the room or data left in the buffer, and the bytes left in the run. A design that ignored the buffer edge would run a burst into the other buffer, and one that ignored the total would keep requesting after the last byte. The bench holds `dack` and `dstb` high after a request has fallen. A design that counted those strobes, or re-requested without waiting for the release, would record a wrong length or raise `dreq` too early. Runs cut short by `eot` or by clearing the enable check that a partial IN buffer is handed over with its true length, while an empty one is left alone. Leaving the enable high after `done` would expose a design that restarts by itself.

// File: rtl/dma_pingpong_ctl.sv
module dma_pingpong_ctl #(
  parameter int LENW = 7,
  parameter int BW   = 4,
  parameter int TW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            dir_out,
  input  logic [LENW-1:0] cfg_size,
  input  logic [BW-1:0]   cfg_burst,
  input  logic [TW-1:0]   cfg_total,
  output logic            dreq,
  input  logic            dack,
  input  logic            dstb,
  input  logic            eot,
  input  logic            usb_pop,
  input  logic            usb_push,
  input  logic [LENW-1:0] usb_len,
  output logic            busy,
  output logic            done,
  output logic            dma_sel,
  output logic [1:0]      buf_rdy,
  output logic [LENW-1:0] len0,
  output logic [LENW-1:0] len1
);

  logic            run, lock, dreq_q, done_q, dsel, usel;
  logic [1:0]      rdy;
  logic [LENW-1:0] blen [2];
  logic [LENW-1:0] pos;
  logic [BW-1:0]   bcnt;
  logic [TW-1:0]   tot;

  wire             mv        = dreq_q & dack & dstb;
  wire             start     = !run && en && !lock;
  wire [LENW-1:0]  pos_inc   = pos + LENW'(1);
  wire [LENW-1:0]  cur_len   = blen[dsel];
  wire             burst_hit = mv && ((bcnt + BW'(1)) == cfg_burst);
  wire             tot_hit   = mv && ((tot + TW'(1)) == cfg_total);
  wire             fill_hit  = mv && !dir_out && (pos_inc == cfg_size);
  wire             drain_hit = mv && dir_out && (pos_inc == cur_len);
  wire             term      = run && (!en || eot || tot_hit);
  wire             avail     = dir_out ? rdy[dsel] : !rdy[dsel];
  wire             in_close  = !dir_out && (fill_hit || (term && (mv || pos != '0)));
  wire             swap_dma  = in_close || drain_hit;
  wire             pop_ok    = usb_pop && !dir_out && rdy[usel];
  wire             push_ok   = usb_push && dir_out && !rdy[usel] && (usb_len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      lock   <= 1'b0;
      done_q <= 1'b0;
      dreq_q <= 1'b0;
      dsel   <= 1'b0;
      usel   <= 1'b0;
      rdy    <= '0;
      pos    <= '0;
      bcnt   <= '0;
      tot    <= '0;
      for (int i = 0; i < 2; i++) blen[i] <= '0;
    end else begin
      if (term)       run <= 1'b0;
      else if (start) run <= 1'b1;

      if (term)     lock <= 1'b1;
      else if (!en) lock <= 1'b0;

      done_q <= term;

      if (start)   tot <= '0;
      else if (mv) tot <= tot + TW'(1);

      if (!dreq_q) bcnt <= '0;
      else if (mv) bcnt <= bcnt + BW'(1);

      if (term || burst_hit || fill_hit || drain_hit)
        dreq_q <= 1'b0;
      else if (!dreq_q && run && avail && !dack)
        dreq_q <= 1'b1;

      if (swap_dma) begin
        pos  <= '0;
        dsel <= ~dsel;
      end else if (mv) begin
        pos <= pos_inc;
      end

      if (pop_ok || push_ok) usel <= ~usel;

      for (int i = 0; i < 2; i++) begin
        if (swap_dma && dsel == 1'(i)) begin
          rdy[i] <= !dir_out;
          if (!dir_out) blen[i] <= mv ? pos_inc : pos;
        end else if ((pop_ok || push_ok) && usel == 1'(i)) begin
          rdy[i] <= dir_out;
          if (push_ok) blen[i] <= usb_len;
        end
      end
    end
  end

  assign dreq    = dreq_q;
  assign done    = done_q;
  assign busy    = run;
  assign dma_sel = dsel;
  assign buf_rdy = rdy;
  assign len0    = blen[0];
  assign len1    = blen[1];

  p_req_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q && !dir_out |-> run && !rdy[dsel]);

  p_req_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q && dir_out |-> run && rdy[dsel]);

  p_burst_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_q && cfg_burst != '0 |-> bcnt < cfg_burst);

  p_rearm_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq_q) |-> $past(!dack));

  p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit |=> rdy[$past(dsel)] && !dreq_q && dsel != $past(dsel));

  p_drain_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hit |=> !rdy[$past(dsel)] && !dreq_q);

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !run && !dreq_q && done_q);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_no_self_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && en |=> !run);

endmodule

// File: tb/dma_pingpong_ctl_tb.sv
module dma_pingpong_ctl_tb;
  localparam int LENW = 7;
  localparam int BW   = 4;
  localparam int TW   = 12;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dir_out = 1'b0;
  logic [LENW-1:0] cfg_size = '0, usb_len = '0;
  logic [BW-1:0]   cfg_burst = '0;
  logic [TW-1:0]   cfg_total = '0;
  logic dack = 1'b0, dstb = 1'b0, eot = 1'b0, usb_pop = 1'b0, usb_push = 1'b0;
  logic dreq, busy, done, dma_sel;
  logic [1:0] buf_rdy;
  logic [LENW-1:0] len0, len1;

  dma_pingpong_ctl #(.LENW(LENW), .BW(BW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_out(dir_out), .cfg_size(cfg_size),
    .cfg_burst(cfg_burst), .cfg_total(cfg_total), .dreq(dreq), .dack(dack),
    .dstb(dstb), .eot(eot), .usb_pop(usb_pop), .usb_push(usb_push),
    .usb_len(usb_len), .busy(busy), .done(done), .dma_sel(dma_sel),
    .buf_rdy(buf_rdy), .len0(len0), .len1(len1));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  bit m_rdy [2];
  int m_len [2];
  int m_pos = 0, m_tot = 0, m_dsel = 0, m_usel = 0;
  int c_size = 1, c_beff = 16, c_teff = 1;
  bit c_out = 0;

  function automatic int min3(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  function automatic bit m_avail();
    return c_out ? m_rdy[m_dsel] : !m_rdy[m_dsel];
  endfunction

  function automatic int exp_burst();
    int rem = c_out ? m_len[m_dsel] - m_pos : c_size - m_pos;
    return min3(c_beff, rem, c_teff - m_tot);
  endfunction

  task automatic model_close_in();
    m_rdy[m_dsel] = 1; m_len[m_dsel] = m_pos; m_dsel ^= 1; m_pos = 0;
  endtask

  task automatic model_advance(input int n);
    m_pos += n; m_tot += n;
    if (c_out) begin
      if (m_pos == m_len[m_dsel]) begin m_rdy[m_dsel] = 0; m_dsel ^= 1; m_pos = 0; end
    end else if (m_pos == c_size || (m_tot >= c_teff && m_pos > 0)) begin
      model_close_in();
    end
  endtask

  task automatic check_bufs(input string rq);
    int e = {m_rdy[1], m_rdy[0]};
    chk(int'(buf_rdy) == e, rq, "buf_rdy", int'(buf_rdy), e);
    chk(int'(len0) == m_len[0], rq, "len0", int'(len0), m_len[0]);
    chk(int'(len1) == m_len[1], rq, "len1", int'(len1), m_len[1]);
    chk(int'(dma_sel) == m_dsel, rq, "dma_sel", int'(dma_sel), m_dsel);
  endtask

  task automatic usb_act();
    if (c_out) begin
      usb_len = LENW'(1 + $urandom % c_size);
      usb_push = 1'b1;
      if (!m_rdy[m_usel]) begin m_rdy[m_usel] = 1; m_len[m_usel] = int'(usb_len); m_usel ^= 1; end
    end else begin
      usb_pop = 1'b1;
      if (m_rdy[m_usel]) begin m_rdy[m_usel] = 0; m_usel ^= 1; end
    end
    @(negedge clk);
    usb_pop = 1'b0; usb_push = 1'b0;
  endtask

  task automatic wait_req(input string rq);
    int w = 0;
    while (!dreq && w < 64) begin @(negedge clk); w++; end
    if (!dreq) chk(1'b0, rq, "request timeout", 0, 1);
  endtask

  task automatic do_burst(output int n);
    n = 0;
    wait_req(c_out ? "R2" : "R1");
    if (!dreq) return;
    dstb = 1'b1;
    @(negedge clk);
    dack = 1'b1;
    while (dreq && n < 300) begin
      dstb = ($urandom % 4) != 0;
      if (dstb) n++;
      @(negedge clk);
    end
    dstb = 1'b0; dack = 1'b0;
  endtask

  task automatic start_xfer(input bit out, input int size, input int burst, input int total);
    dir_out = out; cfg_size = LENW'(size); cfg_burst = BW'(burst); cfg_total = TW'(total);
    c_out = out; c_size = size;
    c_beff = (burst == 0) ? 16 : burst;
    c_teff = (total == 0) ? 4096 : total;
    m_tot = 0;
    en = 1'b1;
  endtask

  task automatic finish_xfer();
    @(negedge clk);
    chk(done == 1'b0, "R10", "done width", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(!dreq && !busy, "R10", "no restart while enabled", int'(busy), 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_xfer(input bit out, input int size, input int burst, input int total);
    bit ended = 0;
    int n, e;
    start_xfer(out, size, burst, total);
    while (!ended) begin
      if (m_avail()) begin
        e = exp_burst();
        do_burst(n);
        model_advance(n);
        ended = (m_tot >= c_teff);
        chk(n == e, "R3", "burst bytes", n, e);
        chk(done == ended, "R7", "done at end", int'(done), int'(ended));
        check_bufs(c_out ? "R6" : "R5");
        if (!ended && m_avail()) begin
          @(negedge clk);
          chk(dreq == 1'b1, "R4", "re-request", int'(dreq), 1);
        end
      end else begin
        repeat (3) @(negedge clk);
        chk(dreq == 1'b0, c_out ? "R2" : "R1", "no request", int'(dreq), 0);
        usb_act();
      end
    end
    finish_xfer();
  endtask

  task automatic free_dsel();
    while (m_rdy[m_dsel]) usb_act();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_rdy[0] = 0; m_rdy[1] = 0; m_len[0] = 0; m_len[1] = 0;
    repeat (3) @(negedge clk);
    chk(!dreq && !done && !busy, "R11", "reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bufs("R11");

    usb_act();
    check_bufs("R9");

    run_xfer(1'b0, 8, 3, 20);
    run_xfer(1'b0, 40, 0, 20);

    // R7 and R8: eot cuts a burst short, the partial buffer is handed over
    free_dsel();
    start_xfer(1'b0, 10, 8, 100);
    wait_req("R1");
    dack = 1'b1; dstb = 1'b1;
    repeat (3) @(negedge clk);
    dstb = 1'b0; eot = 1'b1;
    @(negedge clk);
    eot = 1'b0; dack = 1'b0;
    m_pos += 3; m_tot += 3;
    model_close_in();
    chk(!dreq && done, "R7", "eot ends run", int'(done), 1);
    check_bufs("R8");
    finish_xfer();

    // R7 and R8: clearing the enable with an empty active buffer
    free_dsel();
    start_xfer(1'b0, 10, 8, 100);
    wait_req("R1");
    en = 1'b0;
    @(negedge clk);
    chk(!dreq && done, "R7", "enable clear ends run", int'(done), 1);
    check_bufs("R8");
    @(negedge clk);

    // R4 and R3: acknowledge held after the request falls
    free_dsel();
    start_xfer(1'b0, 10, 2, 100);
    wait_req("R1");
    dack = 1'b1; dstb = 1'b1;
    while (dreq) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dreq == 1'b0, "R4", "held ack blocks request", int'(dreq), 0);
    dack = 1'b0; dstb = 1'b0;
    @(negedge clk);
    chk(dreq == 1'b1, "R4", "request after release", int'(dreq), 1);
    eot = 1'b1;
    @(negedge clk);
    eot = 1'b0;
    m_pos += 2; m_tot += 2;
    model_close_in();
    check_bufs("R3");
    finish_xfer();

    for (int k = 0; k < 12; k++)
      run_xfer(1'b0, 1 + $urandom % 20, $urandom % 16, 1 + $urandom % 50);

    while (m_rdy[0] || m_rdy[1]) usb_act();

    // R9: a zero-length packet is not accepted
    dir_out = 1'b1; c_out = 1'b1;
    usb_len = '0; usb_push = 1'b1;
    @(negedge clk);
    usb_push = 1'b0;
    @(negedge clk);
    check_bufs("R9");

    run_xfer(1'b1, 12, 2, 9);
    for (int k = 0; k < 12; k++)
      run_xfer(1'b1, 1 + $urandom % 20, $urandom % 16, 1 + $urandom % 50);

    report();
  end
endmodule